// File: doc/BRIEF.md
# Serial Control Register Port

This block receives 16-bit command words from a host processor's synchronous serial port and stores them in a small bank of control registers. The registers drive the clock generator and the converter datapath. Every write is two words long: the first word names the register and the second word carries the value to store. Besides the raw register contents, the block brings out a few decoded controls: the operating mode, an interpolator enable, a power-up flag and a one-cycle soft-reset pulse.

The block runs entirely on the serial clock. A frame-sync pulse one clock wide marks the start of each word, and the 16 data bits follow on the next 16 rising edges, most significant bit first. The serial line cannot be held back, so the block exerts no back-pressure. It accepts every complete word the host sends. An address word that names a register outside the bank makes the block drop the data word that follows. Entering the synchronous-terminal mode from any other mode produces a soft-reset pulse, which the clock dividers use to restart.

Top module: `sctl_port`

## Requirements
- R1: After reset all five registers read 0x0000, and op_mode, interp_en, pwr_up and soft_rst are all 0.
- R2: A word begins with fsync high for one rising edge. sdata is then sampled on the next 16 rising edges, most significant bit first.
- R3: Words alternate in role. The first word after reset is an address and the second is data. When the address is below 5, the data word is stored in that register at the rising edge after the one that samples the last data bit. No other event changes a register.
- R4: An address word of 5 or more causes the following data word to be discarded, with every register unchanged. The next word is then treated as an address again.
- R5: interp_en equals bit 9 of register 0.
- R6: op_mode equals bits 2:0 of register 0. The code 3'd4 selects the synchronous-terminal mode.
- R7: Any data write to register 1 sets pwr_up. pwr_up then stays set until reset.
- R8: soft_rst is high for exactly one cycle, the cycle in which a new register 0 value becomes visible, when that write changes bits 2:0 from a value other than 4 to 4. Any other write leaves soft_rst low. A soft reset leaves the register contents unchanged.
- R9: Reset in the middle of a transaction discards a pending address. The first word after reset is an address.
- R10: The word stream 0x0000, 0x0254, 0x0002, 0x0002, 0x0003, 0x0023, 0x0001, 0x0018 leaves register 0 = 0x0254, register 1 = 0x0018, register 2 = 0x0002 and register 3 = 0x0023. It also leaves interp_en = 1, pwr_up = 1 and op_mode = 4, and it raises soft_rst once, on the register 0 write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame-sync pulse preceding each word |
| sdata | input | 1 | Serial data, MSB first |
| ctl_regs | output | 80 | Register contents; register i occupies bits 16*i+15 to 16*i |
| op_mode | output | 3 | Operating-mode field of register 0 |
| interp_en | output | 1 | Interpolator enable |
| pwr_up | output | 1 | Set once register 1 has been written |
| soft_rst | output | 1 | One-cycle soft-reset pulse |

## Verification
Take the rising edge that samples fsync as edge 0. The last data bit is sampled at edge 16, and a register and its decoded outputs change at edge 17. soft_rst is high only between edges 17 and 18. The bench drives inputs and samples outputs on falling edges. It checks registers at the first falling edge after edge 17, and checks soft_rst at that edge and again one falling edge later, so every check lands inside the cycle where a result is due. It sweeps every address from 0 to 7 and all 64 pairs of old and new mode values.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int WORD_W    = 16;
  localparam int NUM_REGS  = 5;
  localparam int MODE_REG  = 0;
  localparam int MODE_LSB  = 0;
  localparam int MODE_W    = 3;
  localparam int INTERP_BIT = 9;
  localparam int PWR_REG   = 1;
  localparam logic [MODE_W-1:0] MODE_SYNC = 3'd4;

  typedef enum logic {PH_ADDR, PH_DATA} phase_e;
endpackage

// File: rtl/sctl_deser.sv
module sctl_deser #(
  parameter int W = sctl_pkg::WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fsync,
  input  logic         sdata,
  output logic         word_vld,
  output logic [W-1:0] word
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] bits_left;
  logic [W-1:0]  shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_left <= '0;
      shreg     <= '0;
      word_vld  <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (fsync) begin
        bits_left <= CW'(W);
      end else if (bits_left != '0) begin
        shreg     <= {shreg[W-2:0], sdata};
        bits_left <= bits_left - 1'b1;
        if (bits_left == CW'(1)) word_vld <= 1'b1;
      end
    end
  end

  assign word = shreg;

  // R2: a word needs 16 sampled bits, so completion can never repeat on consecutive cycles
  a_r2_word_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld);
endmodule

// File: rtl/sctl_pair.sv
module sctl_pair #(
  parameter int W    = sctl_pkg::WORD_W,
  parameter int NREG = sctl_pkg::NUM_REGS,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_vld,
  input  logic [W-1:0]  word,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [W-1:0]  wr_data
);
  import sctl_pkg::*;

  phase_e       phase;
  logic [W-1:0] addr_q;
  logic         addr_ok;

  assign addr_ok = addr_q < W'(NREG);
  assign wr_en   = word_vld && (phase == PH_DATA) && addr_ok;
  assign wr_addr = addr_q[AW-1:0];
  assign wr_data = word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_ADDR;
      addr_q <= '0;
    end else if (word_vld) begin
      if (phase == PH_ADDR) begin
        addr_q <= word;
        phase  <= PH_DATA;
      end else begin
        phase  <= PH_ADDR;
      end
    end
  end

  // R4: no write strobe ever carries an out-of-range register index
  a_r4_no_bad_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < NREG));
  // R3: a completed word always flips the address/data phase
  a_r3_phase_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> (phase != $past(phase)));
endmodule

// File: rtl/sctl_bank.sv
module sctl_bank #(
  parameter int W    = sctl_pkg::WORD_W,
  parameter int NREG = sctl_pkg::NUM_REGS,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [W-1:0]          wr_data,
  output logic [NREG-1:0][W-1:0] regs,
  output logic                  pwr_up,
  output logic                  soft_rst
);
  import sctl_pkg::*;

  logic [MODE_W-1:0] old_mode, new_mode;
  logic              enter_sync;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               regs[i] <= '0;
      else if (wr_en && wr_addr == AW'(i))      regs[i] <= wr_data;
    end
  end

  assign old_mode   = regs[MODE_REG][MODE_LSB +: MODE_W];
  assign new_mode   = wr_data[MODE_LSB +: MODE_W];
  assign enter_sync = wr_en && (wr_addr == AW'(MODE_REG)) &&
                      (new_mode == MODE_SYNC) && (old_mode != MODE_SYNC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_up   <= 1'b0;
      soft_rst <= 1'b0;
    end else begin
      soft_rst <= enter_sync;
      if (wr_en && wr_addr == AW'(PWR_REG)) pwr_up <= 1'b1;
    end
  end

  // R3: registers hold unless a write strobe was present
  a_r3_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs));
  // R7: power-up flag is sticky
  a_r7_pwr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_up |=> pwr_up);
  // R8: pulse is one cycle wide and only seen with sync mode stored
  a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst);
  a_r8_pulse_mode: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (regs[MODE_REG][MODE_LSB +: MODE_W] == MODE_SYNC));
endmodule

// File: rtl/sctl_port.sv
module sctl_port #(
  parameter int W    = sctl_pkg::WORD_W,
  parameter int NREG = sctl_pkg::NUM_REGS
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              sdata,
  output logic [NREG*W-1:0] ctl_regs,
  output logic [2:0]        op_mode,
  output logic              interp_en,
  output logic              pwr_up,
  output logic              soft_rst
);
  import sctl_pkg::*;
  localparam int AW = $clog2(NREG);

  logic                   word_vld;
  logic [W-1:0]           word;
  logic                   wr_en;
  logic [AW-1:0]          wr_addr;
  logic [W-1:0]           wr_data;
  logic [NREG-1:0][W-1:0] regs;

  sctl_deser #(.W(W)) u_deser (
    .clk(sclk), .rst_n(rst_n), .fsync(fsync), .sdata(sdata),
    .word_vld(word_vld), .word(word)
  );

  sctl_pair #(.W(W), .NREG(NREG)) u_pair (
    .clk(sclk), .rst_n(rst_n), .word_vld(word_vld), .word(word),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  sctl_bank #(.W(W), .NREG(NREG)) u_bank (
    .clk(sclk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .regs(regs), .pwr_up(pwr_up), .soft_rst(soft_rst)
  );

  assign ctl_regs  = regs;
  assign op_mode   = regs[MODE_REG][MODE_LSB +: MODE_W];
  assign interp_en = regs[MODE_REG][INTERP_BIT];
endmodule

// File: tb/sctl_port_test.sv
module sctl_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 5;

  logic sclk = 1'b0;
  logic rst_n = 1'b0;
  logic fsync = 1'b0;
  logic sdata = 1'b0;
  logic [NR*16-1:0] ctl_regs;
  logic [2:0] op_mode;
  logic interp_en, pwr_up, soft_rst;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [15:0] exp_reg [NR];
  logic exp_pwr;

  always #(CLK_PERIOD/2) sclk = ~sclk;

  sctl_port uut (
    .sclk(sclk), .rst_n(rst_n), .fsync(fsync), .sdata(sdata),
    .ctl_regs(ctl_regs), .op_mode(op_mode), .interp_en(interp_en),
    .pwr_up(pwr_up), .soft_rst(soft_rst)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < NR; i++)
      chk(tag, 32'(ctl_regs[i*16 +: 16]), 32'(exp_reg[i]));
    chk({tag, " R6 op_mode"}, 32'(op_mode), 32'(exp_reg[0][2:0]));
    chk({tag, " R5 interp_en"}, 32'(interp_en), 32'(exp_reg[0][9]));
    chk({tag, " R7 pwr_up"}, 32'(pwr_up), 32'(exp_pwr));
  endtask

  task automatic send_word(input logic [15:0] w);
    fsync = 1'b1;
    @(negedge sclk);
    fsync = 1'b0;
    for (int b = 15; b >= 0; b--) begin
      sdata = w[b];
      @(negedge sclk);
    end
    sdata = 1'b0;
  endtask

  // returns at the falling edge just after the register update edge
  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    send_word(a);
    send_word(d);
    @(negedge sclk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge sclk);
    @(negedge sclk);
    rst_n = 1'b1;
    for (int i = 0; i < NR; i++) exp_reg[i] = 16'h0000;
    exp_pwr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge sclk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    @(negedge sclk);
    do_reset();
    @(negedge sclk);
    check_all("R1 reset state");
    chk("R1 soft_rst", 32'(soft_rst), 0);

    // R10: example configuration sequence
    wr(16'h0000, 16'h0254);
    exp_reg[0] = 16'h0254;
    chk("R10 R8 soft_rst on entry", 32'(soft_rst), 1);
    @(negedge sclk);
    chk("R8 pulse one cycle", 32'(soft_rst), 0);
    wr(16'h0002, 16'h0002); exp_reg[2] = 16'h0002;
    wr(16'h0003, 16'h0023); exp_reg[3] = 16'h0023;
    wr(16'h0001, 16'h0018); exp_reg[1] = 16'h0018; exp_pwr = 1'b1;
    check_all("R10 example");
    chk("R10 interp on", 32'(interp_en), 1);
    chk("R10 mode sync", 32'(op_mode), 4);

    // R3 R4 R2: sweep every address 0..7 with distinct patterns
    do_reset();
    for (int a = 0; a < 8; a++) begin
      logic [15:0] d;
      d = (16'h1111 * 16'(a + 1)) ^ 16'hA5A5;
      wr(16'(a), d);
      if (a < NR) exp_reg[a] = d;
      if (a == 1) exp_pwr = 1'b1;
      check_all(a < NR ? "R3 addr sweep" : "R4 bad addr discarded");
    end
    // R4: pairing resumes after discarded word
    wr(16'h0004, 16'h8001); exp_reg[4] = 16'h8001;
    check_all("R4 R2 resume and MSB-first");
    wr(16'h0004, 16'h0001); exp_reg[4] = 16'h0001;
    check_all("R2 bit order low");

    // R8: all 64 old/new mode pairs
    for (int o = 0; o < 8; o++) begin
      for (int n = 0; n < 8; n++) begin
        wr(16'h0000, 16'h0200 | 16'(o));
        @(negedge sclk);
        wr(16'h0000, 16'h0100 | 16'(n));
        exp_reg[0] = 16'h0100 | 16'(n);
        chk("R8 soft_rst pulse", 32'(soft_rst), (n == 4 && o != 4) ? 1 : 0);
        check_all("R8 regs untouched");
        @(negedge sclk);
        chk("R8 pulse ends", 32'(soft_rst), 0);
      end
    end

    // R9: reset with an address pending
    send_word(16'h0002);
    do_reset();
    @(negedge sclk);
    check_all("R9 R1 reset mid-pair");
    wr(16'h0003, 16'h0BCD); exp_reg[3] = 16'h0BCD;
    check_all("R9 first word is address");

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule